// File: doc/BRIEF.md
# Pulse-Swallow Digital Phase-Locked Loop

This block is a fully digital phase-locked loop that runs in a single fast clock domain. A reference input is compared against a divided-down feedback clock by an exclusive-OR phase detector. The detector output sets whether a modulo-K loop-filter counter counts up or down. When that counter overflows upward it produces a carry, and when it underflows downward it produces a borrow. A carry makes the pulse stage insert one extra half-cycle into its output. A borrow makes it delete one.

The pulse stage output is the recovered clock. When no correction is pending it toggles on every clock, so it runs at half the clock rate. Its half-cycles then pass through a programmable prescaler and a divide-by-N stage, and the result is the feedback clock. The loop can only correct itself by whole pulses. Its pull range therefore shrinks as K, N and the prescaler ratio grow, and a small offset takes a long time to lock. At most one correction is honoured per reference period. A lock flag reports a run of reference periods with no loop activity.

Top module: `pulse_adpll`

## Requirements
- R1: A synchronous reset clears every counter and drives recClk, fbClk and locked to 0 from the first clock edge at which reset is sampled high.
- R2: In any cycle without an applied correction, recClk changes level, so with no corrections recClk is the clock divided by two.
- R3: fbClk changes level once for every nMod·preMod half-cycles counted at the pulse stage since reset. With no corrections its period is 2·nMod·preMod clocks. preMod and nMod must be at least 1. nMod must be at least 2.
- R4: The loop counter starts at 0 after reset. It counts up in a cycle where refIn XOR fbClk is 1 and down where it is 0, modulo kMod, with kMod at least 2.
- R5: Counting up from kMod-1 wraps the loop counter to 0 and raises a carry. An applied carry adds one extra half-cycle, so that cycle contributes two half-cycles and recClk holds its level.
- R6: Counting down from 0 wraps the loop counter to kMod-1 and raises a borrow. An applied borrow removes the half-cycle of that cycle, so recClk holds its level.
- R7: A window runs from one cycle in which refIn is 1 after being 0 in the previous cycle (refIn is taken as 0 before the first cycle after reset) up to the next such cycle. At most one carry or borrow is applied per window, and the window opened by a rising cycle includes that cycle. Further carries or borrows in the same window still wrap the loop counter, but they have no effect on recClk or fbClk. Before the first rising cycle, one correction is allowed.
- R8: locked rises after lockLen consecutive rising cycles of refIn with no carry or borrow, whether applied or dropped. Any carry or borrow clears it at the next edge and restarts the count. A rising cycle that also holds a carry or borrow counts as loop activity, not as a quiet period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock driving the loop counter and the pulse stage |
| rst | input | 1 | Synchronous active-high reset |
| refIn | input | 1 | Reference input, synchronous to clk |
| kMod | input | KW | Loop-filter counter modulus (at least 2) |
| preMod | input | PW | Prescaler ratio in pulse-stage half-cycles (at least 1) |
| nMod | input | NW | Feedback divider ratio (at least 2) |
| lockLen | input | LW | Quiet reference periods needed to assert lock |
| recClk | output | 1 | Recovered clock from the pulse stage |
| fbClk | output | 1 | Divided feedback clock fed to the phase detector |
| locked | output | 1 | Lock indication |

## Verification
A wrong loop-counter value or direction shows up as a carry or borrow at the wrong cycle. That moves the total count of half-cycles by one, and within the next nMod·preMod half-cycles it becomes a visible shift in the number of fbClk transitions and in the final level of recClk. A gating flag that fails to re-arm or fails to block shows up in the same totals over a single long run with refIn held constant. A lock counter that is off by one shows up at the exact cycle where locked rises, or fails to fall after a wrap. So the lock flag is compared cycle by cycle against an expectation computed from the bench's own refIn waveform and the known wrap cycles.

// File: rtl/adpll_pkg.sv
`timescale 1ns/1ps
package adpll_pkg;
  // Correction strobes from the loop control to the pulse datapath.
  typedef struct packed {
    logic addHalf;   // insert one half-cycle this clock
    logic dropHalf;  // delete this clock's half-cycle
  } corr_t;
endpackage

// File: rtl/adpll_halfdiv.sv
`timescale 1ns/1ps
// Counts incoming half-cycle steps (0..2 per clock) and emits one output
// step for every `modulus` input steps.
module adpll_halfdiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] modulus,
  input  logic [1:0]   stepIn,
  output logic [1:0]   stepOut
);
  localparam int SW = W + 2;

  logic [W-1:0]  cnt, cntNext;
  logic [SW-1:0] sum, modOne, modTwo;

  always_comb begin
    modOne = SW'(modulus);
    modTwo = modOne << 1;
    sum    = SW'(cnt) + SW'(stepIn);
    if (sum >= modTwo) begin
      stepOut = 2'd2;
      cntNext = W'(sum - modTwo);
    end else if (sum >= modOne) begin
      stepOut = 2'd1;
      cntNext = W'(sum - modOne);
    end else begin
      stepOut = 2'd0;
      cntNext = W'(sum);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end

  // R3
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < modulus);
endmodule

// File: rtl/adpll_path.sv
`timescale 1ns/1ps
// Pulse datapath: add/swallow stage, prescaler and feedback divider.
module adpll_path
  import adpll_pkg::*;
#(
  parameter int PW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  corr_t         corr,
  input  logic [PW-1:0] preMod,
  input  logic [NW-1:0] nMod,
  output logic          recClk,
  output logic          fbClk
);
  logic [1:0] idStep;
  logic [1:0] preStep;
  logic [1:0] fbStep;

  // Half-cycles produced this clock: 1 nominal, 2 on add, 0 on swallow.
  always_comb begin
    if (corr.addHalf)       idStep = 2'd2;
    else if (corr.dropHalf) idStep = 2'd0;
    else                    idStep = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                recClk <= 1'b0;
    else if (idStep == 2'd1) recClk <= ~recClk;
  end

  adpll_halfdiv #(.W(PW)) u_pre (
    .clk(clk), .rst(rst), .modulus(preMod), .stepIn(idStep), .stepOut(preStep)
  );

  adpll_halfdiv #(.W(NW)) u_fbdiv (
    .clk(clk), .rst(rst), .modulus(nMod), .stepIn(preStep), .stepOut(fbStep)
  );

  always_ff @(posedge clk) begin
    if (rst)                 fbClk <= 1'b0;
    else if (fbStep == 2'd1) fbClk <= ~fbClk;
  end

  // R2
  id_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !(corr.addHalf || corr.dropHalf) |=> recClk != $past(recClk));

  // R5 R6
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (corr.addHalf || corr.dropHalf) |=> recClk == $past(recClk));
endmodule

// File: rtl/adpll_ctrl.sv
`timescale 1ns/1ps
// Loop control: phase detector, modulo-K up/down counter, per-period
// correction gate and lock tracker.
module adpll_ctrl
  import adpll_pkg::*;
#(
  parameter int KW = 20,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          refIn,
  input  logic          fbClk,
  input  logic [KW-1:0] kMod,
  input  logic [LW-1:0] lockLen,
  output corr_t         corr,
  output logic          locked
);
  logic [KW-1:0] kCnt;
  logic [LW-1:0] quietCnt;
  logic pdHigh, refPrev, refRise;
  logic atTop, atBottom, carry, borrow, loopEvent;
  logic usedQ, gateOpen;
  logic quietHit;

  assign pdHigh    = refIn ^ fbClk;
  assign refRise   = refIn & ~refPrev;
  assign atTop     = (kCnt == kMod - 1'b1);
  assign atBottom  = (kCnt == '0);
  assign carry     = pdHigh & atTop;
  assign borrow    = ~pdHigh & atBottom;
  assign loopEvent = carry | borrow;
  assign gateOpen  = refRise | ~usedQ;

  always_comb begin
    corr.addHalf  = carry & gateOpen;
    corr.dropHalf = borrow & gateOpen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kCnt    <= '0;
      refPrev <= 1'b0;
      usedQ   <= 1'b0;
    end else begin
      refPrev <= refIn;
      usedQ   <= (refRise ? 1'b0 : usedQ) | corr.addHalf | corr.dropHalf;
      if (pdHigh) kCnt <= atTop    ? '0            : kCnt + 1'b1;
      else        kCnt <= atBottom ? kMod - 1'b1   : kCnt - 1'b1;
    end
  end

  assign quietHit = ({1'b0, quietCnt} + {{LW{1'b0}}, 1'b1}) >= {1'b0, lockLen};

  always_ff @(posedge clk) begin
    if (rst) begin
      quietCnt <= '0;
      locked   <= 1'b0;
    end else if (loopEvent) begin
      quietCnt <= '0;
      locked   <= 1'b0;
    end else if (refRise) begin
      if (quietCnt < lockLen) quietCnt <= quietCnt + 1'b1;
      if (quietHit) locked <= 1'b1;
    end
  end

  // R5
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    corr.addHalf |=> kCnt == '0);

  // R6
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    corr.dropHalf |=> kCnt == $past(kMod) - 1'b1);

  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(refRise));

  // R8
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (corr.addHalf || corr.dropHalf) |=> !locked);

  // R4
  kcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    kCnt < kMod);
endmodule

// File: rtl/pulse_adpll.sv
`timescale 1ns/1ps
module pulse_adpll #(
  parameter int KW = 20,
  parameter int PW = 16,
  parameter int NW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          refIn,
  input  logic [KW-1:0] kMod,
  input  logic [PW-1:0] preMod,
  input  logic [NW-1:0] nMod,
  input  logic [LW-1:0] lockLen,
  output logic          recClk,
  output logic          fbClk,
  output logic          locked
);
  import adpll_pkg::*;

  corr_t corrStrobe;

  adpll_ctrl #(.KW(KW), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .refIn(refIn), .fbClk(fbClk),
    .kMod(kMod), .lockLen(lockLen), .corr(corrStrobe), .locked(locked)
  );

  adpll_path #(.PW(PW), .NW(NW)) u_path (
    .clk(clk), .rst(rst), .corr(corrStrobe), .preMod(preMod), .nMod(nMod),
    .recClk(recClk), .fbClk(fbClk)
  );
endmodule

// File: tb/pulse_adpll_tb.sv
`timescale 1ns/1ps
module pulse_adpll_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  refMode = 2'd0;   // 0: low, 1: high, 2: follow fbClk, 3: invert fbClk
  logic [19:0] kMod = 20'd100;
  logic [15:0] preMod = 16'd1;
  logic [15:0] nMod = 16'd2;
  logic [7:0]  lockLen = 8'd1;
  logic        refIn, recClk, fbClk, locked;
  int          total = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  assign refIn = (refMode == 2'd0) ? 1'b0 :
                 (refMode == 2'd1) ? 1'b1 :
                 (refMode == 2'd2) ? fbClk : ~fbClk;

  pulse_adpll u_dut (
    .clk(clk), .rst(rst), .refIn(refIn), .kMod(kMod), .preMod(preMod),
    .nMod(nMod), .lockLen(lockLen), .recClk(recClk), .fbClk(fbClk),
    .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic startRun(input logic [1:0] mode, input int k, input int p,
                          input int n, input int l);
    @(negedge clk);
    rst = 1'b1;
    refMode = mode;
    kMod = 20'(k); preMod = 16'(p); nMod = 16'(n); lockLen = 8'(l);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs T cycles after reset, returns fbClk transitions and final recClk.
  task automatic countRun(input int T, output int toggles, output int lastRec);
    logic prevFb;
    prevFb = 1'b0;
    toggles = 0;
    repeat (T) begin
      @(posedge clk);
      @(negedge clk);
      if (fbClk !== prevFb) toggles++;
      prevFb = fbClk;
    end
    lastRec = int'(recClk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int tg, rc, h, c;
    // R1: outputs after reset edges
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(recClk === 1'b0, "R1 recClk in reset", int'(recClk), 0);
    chk(fbClk === 1'b0, "R1 fbClk in reset", int'(fbClk), 0);
    chk(locked === 1'b0, "R1 locked in reset", int'(locked), 0);

    // R2 R3: no corrections, per-cycle waveform (N=3, P=2)
    startRun(2'd3, 65535, 2, 3, 200);
    for (int k = 1; k <= 120; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(int'(recClk) == (k % 2), "R2 recClk toggles every clock", int'(recClk), k % 2);
      chk(int'(fbClk) == ((k / 6) % 2), "R3 fbClk period 2*N*P", int'(fbClk), (k / 6) % 2);
    end

    // R4 R5 R6: sweep N and P, counting up (carries) and down (borrows)
    for (int n = 2; n <= 4; n++) begin
      for (int p = 1; p <= 3; p++) begin
        // Up: refIn = ~fbClk, carries at cycles k-1, 2k-1, ...
        startRun(2'd3, 2 * n * p + 3, p, n, 200);
        countRun(300, tg, rc);
        c = 300 / (2 * n * p + 3);
        h = 300 + c;
        chk(tg == h / (n * p), "R5 fbClk transitions with carries", tg, h / (n * p));
        chk(rc == h % 2, "R5 recClk level with carries", rc, h % 2);
        // Down: refIn = fbClk, borrows at cycles 0, k, 2k, ...
        startRun(2'd2, 2 * n * p + 3, p, n, 200);
        countRun(300, tg, rc);
        c = (300 - 1) / (2 * n * p + 3) + 1;
        h = 300 - c;
        chk(tg == h / (n * p), "R6 fbClk transitions with borrows", tg, h / (n * p));
        chk(rc == h % 2, "R6 recClk level with borrows", rc, h % 2);
      end
    end

    // R7: refIn held low, no rising cycle: only the first borrow applies
    startRun(2'd0, 3, 2, 2, 1);
    countRun(200, tg, rc);
    chk(tg == 199 / 4, "R7 single borrow without reference edge", tg, 199 / 4);
    chk(rc == 199 % 2, "R7 recClk level without reference edge", rc, 199 % 2);
    chk(locked === 1'b0, "R8 no lock without reference edges", int'(locked), 0);

    // R7: refIn held high, one rising cycle at start: only the first carry applies
    startRun(2'd1, 3, 2, 2, 1);
    countRun(200, tg, rc);
    chk(tg == 201 / 4, "R7 single carry after one reference edge", tg, 201 / 4);
    chk(rc == 201 % 2, "R7 recClk level after one reference edge", rc, 201 % 2);

    // R8: lock acquisition and loss, cycle by cycle (carries every 200 cycles)
    startRun(2'd3, 200, 2, 2, 3);
    begin
      int   qCnt;
      bit   expL, prevRef;
      qCnt = 0; expL = 1'b0; prevRef = 1'b0;
      for (int j = 0; j < 450; j++) begin
        bit cur, rise, ev;
        cur  = refIn;
        rise = cur && !prevRef;
        prevRef = cur;
        ev = (j % 200) == 199;
        if (ev) begin
          qCnt = 0; expL = 1'b0;
        end else if (rise) begin
          if (qCnt < 3) qCnt++;
          if (qCnt >= 3) expL = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(locked === expL, "R8 lock flag", int'(locked), int'(expL));
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule